// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Shared Address Pointer

This block is the bus-facing slave of a byte-addressed memory reached over a two-wire serial bus (clock line plus open-drain data line). It oversamples both lines with the system clock and finds start and stop conditions and clock edges. It checks the control byte against a fixed device code and three strap inputs, and acknowledges only its own address. It then runs either a write-direction access or a read-direction access.

A write-direction access carries a 12-bit word address as a high byte followed by a low byte. This loads a single address pointer. Any bytes that follow are written to the memory port at the pointer. A read-direction access sends the byte found at the pointer, most significant bit first, through a synchronous memory read port. The pointer always addresses the memory read port, and it survives across transactions. Every byte read or written advances it by one. A read with no address phase therefore continues just after the last location touched. A random read is a write-direction address phase, then a repeated start, then a read.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the data line is released, the pointer (seen on `mem_rd_addr_o`) is 0, and no write strobe is issued.
- R2: A control byte is accepted only when bits [7:4] equal 1010 and bits [3:1] equal `strap_i`. Bit [0] selects the direction (1 = read). An accepted byte is acknowledged by pulling the data line low for the ninth clock. A rejected byte gets no acknowledge, and every later byte up to the next start is ignored, with no write and no pointer change.
- R3: In a write-direction access, the first two bytes after the control byte are each acknowledged. The first byte supplies address bits [11:8] in its bits [3:0], and the second supplies bits [7:0]. The pointer takes the combined value once the second byte is complete.
- R4: Each further byte of a write-direction access is acknowledged and written to the memory port at the current pointer. The pointer then moves to the next address.
- R5: In a read-direction access, the slave sends the byte read from the pointer, most significant bit first. It starts at the clock fall that ends the control acknowledge. The pointer advances by one for each byte sent.
- R6: A read-direction access with no address phase returns the data at n+1, where n is the last address read or written, even across stop conditions.
- R7: A repeated start after the second address byte keeps the loaded pointer, so the following read returns the byte at that address.
- R8: When the master acknowledges a sent byte, the next sequential byte follows. When it does not, the slave releases the data line and stays silent until the next start.
- R9: The pointer steps from 4095 to 0, for both reads and writes.
- R10: A stop condition at any point returns the slave to idle with the data line released. A byte cut short by a stop is not written.
- R11: Both lines pass a two-flop synchronizer. A start is a falling data line while the clock line is high. Data-line edges while the clock is low are not starts, so bytes that follow such edges without a real start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Pull-down enable for the data line |
| strap_i | input | 3 | Device select straps compared with control bits [3:1] |
| mem_rd_addr_o | output | 12 | Memory read address, always the pointer |
| mem_rd_data_i | input | 8 | Memory read data, one cycle after the address |
| mem_wr_en_o | output | 1 | One-cycle memory write strobe |
| mem_wr_addr_o | output | 12 | Memory write address |
| mem_wr_data_o | output | 8 | Memory write data |

## Verification
The memory write strobe and the pointer step happen in the same cycle, and a byte completing at address 4095 also wraps the pointer in that cycle. A write burst that starts at 4095 provokes this case. The bench judges it by the logged write addresses, which must be 4095 and then 0 (the value before each step), and by a later current-address read, which must return the byte at address 1. Randomized mixes of writes, random reads and current reads also hit the step-while-writing case at random addresses. A bench-side pointer model checks each returned byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} tw_state_e;
  typedef enum logic [1:0] {RK_CTRL, RK_ADRH, RK_ADRL, RK_WDAT} tw_rxkind_e;

  // control byte: [7:4] device code, [3:1] select straps, [0] direction
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [3:0] code,
                                    input logic [2:0] strap);
    return (b[7:4] == code) && (b[3:1] == strap);
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int TOP = STAGES;
  logic [TOP:0] scl_pipe, sda_pipe;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[TOP-1];
  assign scl_p = scl_pipe[TOP];
  assign sda_s = sda_pipe[TOP-1];
  assign sda_p = sda_pipe[TOP];

  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_step(ptr);
  end

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (&ptr)) |=> (ptr == '0));
  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(load_val)));
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(ptr));
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int          ADDR_W      = 12,
  parameter logic [3:0]  DEV_CODE    = 4'b1010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        strap_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [7:0]        mem_wr_data_o
);
  import tw_pkg::*;
  localparam int HI_W = ADDR_W - 8;

  logic sda_s, ev_rise, ev_fall, ev_start, ev_stop;
  tw_state_e  state;
  tw_rxkind_e kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, rx_byte;
  logic [HI_W-1:0] hi_q;
  logic pull, ackon, go_tx, mack;
  logic rx_done, ctrl_ok, ctrl_miss, ptr_load, ptr_inc, wr_fire, tx_load;
  logic [ADDR_W-1:0] ptr;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop));

  tw_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val({hi_q, rx_byte}),
    .inc(ptr_inc), .ptr(ptr));

  // named internal events
  assign rx_byte   = {shreg[6:0], sda_s};
  assign rx_done   = (state == ST_RX) && ev_rise && (bitcnt == 4'd7);
  assign ctrl_ok   = ctrl_hit(rx_byte, DEV_CODE, strap_i);
  assign ctrl_miss = rx_done && (kind == RK_CTRL) && !ctrl_ok;
  assign ptr_load  = rx_done && (kind == RK_ADRL);
  assign wr_fire   = rx_done && (kind == RK_WDAT);
  assign tx_load   = ev_fall && (((state == ST_RXACK) && ackon && go_tx) ||
                                 ((state == ST_TXACK) && mack));
  assign ptr_inc   = wr_fire || tx_load;

  assign sda_pull_o    = pull;
  assign mem_rd_addr_o = ptr;
  assign mem_wr_en_o   = wr_fire;
  assign mem_wr_addr_o = ptr;
  assign mem_wr_data_o = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= RK_CTRL; bitcnt <= '0; shreg <= '0; hi_q <= '0;
      pull <= 1'b0; ackon <= 1'b0; go_tx <= 1'b0; mack <= 1'b0;
    end else if (ev_start) begin
      state <= ST_RX; kind <= RK_CTRL; bitcnt <= '0; pull <= 1'b0; ackon <= 1'b0;
    end else if (ev_stop) begin
      state <= ST_IDLE; pull <= 1'b0; ackon <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (ev_rise) begin
          shreg  <= rx_byte;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            bitcnt <= '0;
            state  <= ST_RXACK;
            go_tx  <= 1'b0;
            unique case (kind)
              RK_CTRL: begin
                if (ctrl_ok) begin go_tx <= rx_byte[0]; kind <= RK_ADRH; end
                else state <= ST_IDLE;
              end
              RK_ADRH: begin hi_q <= rx_byte[HI_W-1:0]; kind <= RK_ADRL; end
              RK_ADRL: kind <= RK_WDAT;
              default: kind <= RK_WDAT;
            endcase
          end
        end
        ST_RXACK: if (ev_fall) begin
          if (!ackon) begin
            pull <= 1'b1; ackon <= 1'b1;
          end else begin
            ackon <= 1'b0; bitcnt <= '0;
            if (go_tx) begin
              state <= ST_TX; shreg <= mem_rd_data_i; pull <= ~mem_rd_data_i[7];
            end else begin
              state <= ST_RX; pull <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (ev_rise) bitcnt <= bitcnt + 4'd1;
          if (ev_fall) begin
            if (bitcnt == 4'd8) begin
              pull <= 1'b0; state <= ST_TXACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0}; pull <= ~shreg[6];
            end
          end
        end
        ST_TXACK: begin
          if (ev_rise) mack <= ~sda_s;
          if (ev_fall) begin
            bitcnt <= '0;
            if (mack) begin
              state <= ST_TX; shreg <= mem_rd_data_i; pull <= ~mem_rd_data_i[7];
            end else begin
              state <= ST_IDLE; pull <= 1'b0;
            end
          end
        end
        default: pull <= 1'b0;
      endcase
    end
  end

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull_o);
  // R2
  ctrl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_miss |=> (state == ST_IDLE) && !sda_pull_o);
  // R4
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |=> (mem_rd_addr_o != $past(mem_rd_addr_o)));
  // R5
  tx_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (sda_pull_o == !$past(mem_rd_data_i[7])));
  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_TXACK) && ev_fall && !mack && !ev_start) |=> !sda_pull_o);
endmodule

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
  localparam int HALF = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_pull, sda_line;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic        wr_en;
  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] exp_ptr = '0;
  logic [19:0] wlog[$];

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | sda_pull);

  tw_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .strap_i(STRAP), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data));

  function automatic logic [7:0] memf(input logic [11:0] a);
    return (a[7:0] * 8'd7) ^ {4'h0, a[11:8]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    rd_data <= memf(rd_addr);
    if (wr_en) wlog.push_back({wr_addr, wr_data});
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; wt(HALF); m_scl = 1'b1; wt(HALF); m_low = 1'b1; wt(HALF);
    m_scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(HALF); m_scl = 1'b1; wt(HALF); m_low = 1'b0; wt(HALF);
  endtask

  task automatic clk_bit(input logic b);
    m_low = ~b; wt(HALF); m_scl = 1'b1; wt(HALF); m_scl = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    m_low = 1'b0; wt(HALF); m_scl = 1'b1; wt(HALF/2); ack = ~sda_line;
    wt(HALF/2); m_scl = 1'b0; wt(2);
  endtask

  task automatic recv_byte(input logic ackit, output logic [7:0] b);
    logic [7:0] r = '0;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wt(HALF); m_scl = 1'b1; wt(HALF/2); r = {r[6:0], sda_line}; wt(HALF/2);
      m_scl = 1'b0; wt(2);
    end
    m_low = ackit; wt(HALF); m_scl = 1'b1; wt(HALF); m_scl = 1'b0; wt(2); m_low = 1'b0;
    b = r;
  endtask

  task automatic addr_phase(input logic [11:0] a);
    logic ack;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack); check("R2 ctrl write ack", ack, 1);
    send_byte({4'h0, a[11:8]}, ack);        check("R3 addr high ack", ack, 1);
    send_byte(a[7:0], ack);                 check("R3 addr low ack", ack, 1);
  endtask

  task automatic read_bytes(input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack); check("R2 ctrl read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check("R5/R8 read byte", b, memf(exp_ptr));
      exp_ptr = exp_ptr + 12'd1;
    end
    wt(4); check("R8 release after nack", sda_pull, 0);
    bus_stop();
    check("R10 released after stop", sda_pull, 0);
  endtask

  task automatic do_write(input logic [11:0] a, input int n, input logic [7:0] base);
    logic ack;
    wlog.delete();
    addr_phase(a);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i * 3), ack); check("R4 data ack", ack, 1);
    end
    bus_stop();
    check("R4 write count", wlog.size(), n);
    for (int i = 0; i < n && i < wlog.size(); i++)
      check("R4/R9 write addr+data", wlog[i], {a + 12'(i), base + 8'(i * 3)});
    exp_ptr = a + 12'(n);
    check("R4 pointer after write", rd_addr, exp_ptr);
  endtask

  task automatic rand_read(input logic [11:0] a, input int n);
    addr_phase(a);
    exp_ptr = a;
    read_bytes(n); // R7 repeated start keeps the loaded pointer
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    int r;
    r = $urandom(32'h00C0FFEE);
    wt(10);
    // R1 reset state
    check("R1 sda released", sda_pull, 0);
    check("R1 pointer zero", rd_addr, 0);
    check("R1 no write", wr_en, 0);
    rst_n = 1'b1; wt(10);
    read_bytes(2);                 // R6 current read from reset pointer
    do_write(12'h123, 2, 8'h40);   // R3 R4
    read_bytes(1);                 // R6 continues at n+1
    rand_read(12'hABC, 3);         // R7 R8
    // R2 wrong straps: nothing acknowledged, nothing written, pointer kept
    wlog.delete();
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack); check("R2 strap miss no ack", ack, 0);
    send_byte(8'h00, ack); check("R2 ignored byte no ack", ack, 0);
    send_byte(8'h10, ack); check("R2 ignored byte no ack", ack, 0);
    send_byte(8'h77, ack); check("R2 ignored byte no ack", ack, 0);
    bus_stop();
    check("R2 no write after miss", wlog.size(), 0);
    check("R2 pointer kept", rd_addr, exp_ptr);
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ack); check("R2 code miss no ack", ack, 0);
    bus_stop();
    check("R2 pointer kept after code miss", rd_addr, exp_ptr);
    // R9 wrap on read and on write
    rand_read(12'hFFF, 2);
    do_write(12'hFFF, 2, 8'h91);
    read_bytes(1);
    // R10 stop in the middle of a data byte
    wlog.delete();
    addr_phase(12'h040);
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
    bus_stop();
    check("R10 partial byte not written", wlog.size(), 0);
    check("R10 released", sda_pull, 0);
    exp_ptr = 12'h040;
    read_bytes(1);
    // R11 data edges with the clock low are not a start
    m_scl = 1'b0; wt(HALF); m_low = 1'b1; wt(HALF); m_low = 1'b0; wt(HALF);
    send_byte({4'b1010, STRAP, 1'b0}, ack); check("R11 no start no ack", ack, 0);
    bus_stop();
    check("R11 pointer kept", rd_addr, exp_ptr);
    // randomized mix
    for (int it = 0; it < 24; it++) begin
      logic [11:0] a;
      int op, n;
      op = int'($urandom % 3);
      n  = 1 + int'($urandom % 3);
      a  = ($urandom % 4 == 0) ? 12'hFFE : 12'($urandom);
      case (op)
        0: do_write(a, n, 8'($urandom));
        1: rand_read(a, n);
        default: read_bytes(n);
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule